// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block drives a small 8-bit datapath one control word per clock. It holds an opcode register and a 4-bit phase counter, which acts as the microprogram counter. Each cycle it forms a 13-bit control-store address from the opcode, the phase and the incoming flag bit. It looks up a 24-bit control word at that address and splits the word into named fields. A 3-bit destination field is decoded into one-hot load enables.

The store contents are computed in logic. They cover the instruction-fetch word and the four-step absolute-address add-with-carry. The last step of every instruction loads the next opcode from the data bus and returns the phase counter to zero, so the fetch of one instruction overlaps the final step of the one before it. Any store address that is not defined yields a word in which every enable is inactive. The datapath is outside this block. The phase counter and opcode register are also driven out, so that the current microprogram position can be seen.

Top module: `usq_seq_top`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, the phase is 0 and the opcode is the fetch opcode (default 8'h00). The fetch word has address source code 0 (PC), pc_inc=1, op_load=1, and every other enable and every load enable is 0.
- R2: On a clock edge where op_load is 1, the opcode register takes data_in and the phase becomes 0.
- R3: On a clock edge where op_load is 0, the opcode register holds and the phase increments by one, wrapping from 15 to 0.
- R4: At add-with-carry (default opcode 8'h6D) phase 0, load_en is 8'h20 (AR low, destination code 5), the address source is 0 (PC), pc_inc=1 and op_load=0.
- R5: At add-with-carry phase 1, load_en is 8'h40 (AR high, code 6), the address source is 0 (PC) and pc_inc=1.
- R6: At add-with-carry phase 2, load_en is 8'h04 (T, code 2), the address source is 1 (AR) and pc_inc=0.
- R7: At add-with-carry phase 3: ALU left select 0 (A), right select 2 (T), function 6'h01 (add with carry), alu_drive=1, load_en 8'h01 (A, code 0), cc_en=1, cc_load=1, address source 0, pc_inc=1 and op_load=1.
- R8: The flag input does not change any of the words defined above.
- R9: Any undefined opcode or phase gives a word with every output field 0, whatever data_in carries.
- R10: load_en never has more than one bit set. Bit i corresponds to destination code i (A=0, X=1, T=2, PC low=3, PC high=4, AR low=5, AR high=6, memory=7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Data bus, source of the next opcode |
| flag_in | input | 1 | Serial condition flag, part of the store address |
| alu_lsel | output | 2 | ALU left operand select |
| alu_rsel | output | 2 | ALU right operand select |
| alu_func | output | 6 | ALU function code |
| alu_drive | output | 1 | ALU result drives the data bus |
| load_en | output | 8 | One-hot load enables by destination code |
| cc_en | output | 1 | Condition register enable |
| cc_load | output | 1 | Condition register parallel load (0 = shift) |
| addr_src | output | 2 | Address bus source: 0 PC, 1 AR, 2 SP |
| ar_inc | output | 1 | Increment AR |
| pc_inc | output | 1 | Increment PC |
| sp_inc | output | 1 | Increment SP |
| sp_dec | output | 1 | Decrement SP |
| op_load | output | 1 | Load opcode register from data_in |
| upc_phase | output | 4 | Current phase |
| upc_opcode | output | 8 | Current opcode |

## Verification
The bench builds the block with its default opcode values: fetch at 8'h00 and add-with-carry at 8'h6D. With these values a fetch-to-add chain, two back-to-back adds with opposite flag patterns, and a return to fetch can all be driven at the data port. Loading the undefined opcode 8'hFF stops the sequence from ever reloading. That makes the phase counter run freely, so its wrap from 15 to 0 can be observed while every enable stays idle.

// File: rtl/usq_pkg.sv
package usq_pkg;
    localparam int OP_W  = 8;
    localparam int PH_W  = 4;
    localparam int SEL_W = 2;
    localparam int FN_W  = 6;
    localparam int DST_W = 3;
    localparam int SRC_W = 2;
    localparam int DST_N = 1 << DST_W;
    localparam int ADR_W = OP_W + PH_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0] alu_l;
        logic [SEL_W-1:0] alu_r;
        logic [FN_W-1:0]  alu_fn;
        logic             alu_drv;
        logic [DST_W-1:0] dst;
        logic             ld_strb;
        logic             cc_en;
        logic             cc_ld;
        logic [SRC_W-1:0] asrc;
        logic             ar_inc;
        logic             pc_inc;
        logic             sp_inc;
        logic             sp_dec;
        logic             op_ld;
    } cword_t;

    typedef struct packed {
        cword_t w;
        logic   flag_care;
        logic   flag_want;
    } store_ent_t;

    localparam logic [SEL_W-1:0] SEL_A  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_T  = 2'd2;
    localparam logic [FN_W-1:0]  FN_ADC = 6'h01;
    localparam logic [DST_W-1:0] DST_A    = 3'd0;
    localparam logic [DST_W-1:0] DST_T    = 3'd2;
    localparam logic [DST_W-1:0] DST_ARLO = 3'd5;
    localparam logic [DST_W-1:0] DST_ARHI = 3'd6;
    localparam logic [SRC_W-1:0] SRC_PC = 2'd0;
    localparam logic [SRC_W-1:0] SRC_AR = 2'd1;
endpackage

// File: rtl/usq_store.sv
module usq_store
    import usq_pkg::*;
#(
    parameter logic [OP_W-1:0] FETCH_OP = 8'h00,
    parameter logic [OP_W-1:0] ADC_OP   = 8'h6D
) (
    input  logic [ADR_W-1:0] addr,
    output cword_t           word
);
    logic [OP_W-1:0] a_op;
    logic [PH_W-1:0] a_ph;
    logic            a_flag;
    store_ent_t      ent;

    assign a_op   = addr[ADR_W-1 -: OP_W];
    assign a_ph   = addr[PH_W:1];
    assign a_flag = addr[0];

    // Entry lookup: defined words ignore the flag (flag_care = 0).
    always_comb begin
        ent = '0;
        if (a_op == FETCH_OP) begin
            if (a_ph == '0) begin
                ent.w.asrc   = SRC_PC;
                ent.w.pc_inc = 1'b1;
                ent.w.op_ld  = 1'b1;
            end
        end else if (a_op == ADC_OP) begin
            case (a_ph)
                PH_W'(0): begin
                    ent.w.dst     = DST_ARLO;
                    ent.w.ld_strb = 1'b1;
                    ent.w.asrc    = SRC_PC;
                    ent.w.pc_inc  = 1'b1;
                end
                PH_W'(1): begin
                    ent.w.dst     = DST_ARHI;
                    ent.w.ld_strb = 1'b1;
                    ent.w.asrc    = SRC_PC;
                    ent.w.pc_inc  = 1'b1;
                end
                PH_W'(2): begin
                    ent.w.dst     = DST_T;
                    ent.w.ld_strb = 1'b1;
                    ent.w.asrc    = SRC_AR;
                end
                PH_W'(3): begin
                    ent.w.alu_l   = SEL_A;
                    ent.w.alu_r   = SEL_T;
                    ent.w.alu_fn  = FN_ADC;
                    ent.w.alu_drv = 1'b1;
                    ent.w.dst     = DST_A;
                    ent.w.ld_strb = 1'b1;
                    ent.w.cc_en   = 1'b1;
                    ent.w.cc_ld   = 1'b1;
                    ent.w.asrc    = SRC_PC;
                    ent.w.pc_inc  = 1'b1;
                    ent.w.op_ld   = 1'b1;
                end
                default: ent = '0;
            endcase
        end
    end

    // A flag-qualified entry whose condition is not met reads as idle.
    always_comb begin
        if (ent.flag_care && (ent.flag_want != a_flag)) begin
            word = '0;
        end else begin
            word = ent.w;
        end
    end
endmodule

// File: rtl/usq_dest_dec.sv
module usq_dest_dec
    import usq_pkg::*;
(
    input  logic [DST_W-1:0] dst,
    input  logic             strb,
    output logic [DST_N-1:0] load_en
);
    for (genvar i = 0; i < DST_N; i++) begin : g_dec
        assign load_en[i] = strb && (dst == DST_W'(i));
    end
endmodule

// File: rtl/usq_seq_top.sv
module usq_seq_top
    import usq_pkg::*;
#(
    parameter logic [OP_W-1:0] FETCH_OP = 8'h00,
    parameter logic [OP_W-1:0] ADC_OP   = 8'h6D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  data_in,
    input  logic             flag_in,
    output logic [SEL_W-1:0] alu_lsel,
    output logic [SEL_W-1:0] alu_rsel,
    output logic [FN_W-1:0]  alu_func,
    output logic             alu_drive,
    output logic [DST_N-1:0] load_en,
    output logic             cc_en,
    output logic             cc_load,
    output logic [SRC_W-1:0] addr_src,
    output logic             ar_inc,
    output logic             pc_inc,
    output logic             sp_inc,
    output logic             sp_dec,
    output logic             op_load,
    output logic [PH_W-1:0]  upc_phase,
    output logic [OP_W-1:0]  upc_opcode
);
    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [PH_W-1:0] ph;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    cword_t           cw;
    logic [ADR_W-1:0] store_addr;

    assign store_addr = {st_q.op, st_q.ph, flag_in};

    usq_store #(
        .FETCH_OP (FETCH_OP),
        .ADC_OP   (ADC_OP)
    ) store_i (
        .addr (store_addr),
        .word (cw)
    );

    usq_dest_dec dec_i (
        .dst     (cw.dst),
        .strb    (cw.ld_strb),
        .load_en (load_en)
    );

    always_comb begin
        st_d = st_q;
        if (cw.op_ld) begin
            st_d.op = data_in;
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op <= FETCH_OP;
            st_q.ph <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alu_lsel   = cw.alu_l;
    assign alu_rsel   = cw.alu_r;
    assign alu_func   = cw.alu_fn;
    assign alu_drive  = cw.alu_drv;
    assign cc_en      = cw.cc_en;
    assign cc_load    = cw.cc_ld;
    assign addr_src   = cw.asrc;
    assign ar_inc     = cw.ar_inc;
    assign pc_inc     = cw.pc_inc;
    assign sp_inc     = cw.sp_inc;
    assign sp_dec     = cw.sp_dec;
    assign op_load    = cw.op_ld;
    assign upc_phase  = st_q.ph;
    assign upc_opcode = st_q.op;

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_en)); // R10
    AST_OP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        op_load |=> (upc_opcode == $past(data_in))); // R2
    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_load |=> (upc_phase == '0)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !op_load |=> (upc_phase == PH_W'($past(upc_phase) + 1'b1))); // R3
    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_load |=> $stable(upc_opcode)); // R3
    AST_CC_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load |-> (cc_en && alu_drive && load_en[0])); // R7
endmodule

// File: tb/usq_seq_top_tb_top.sv
module usq_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       flag_in = 1'b0;
    logic [1:0] alu_lsel, alu_rsel, addr_src;
    logic [5:0] alu_func;
    logic [7:0] load_en;
    logic       alu_drive, cc_en, cc_load, ar_inc, pc_inc, sp_inc, sp_dec, op_load;
    logic [3:0] upc_phase;
    logic [7:0] upc_opcode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usq_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .flag_in(flag_in),
        .alu_lsel(alu_lsel), .alu_rsel(alu_rsel), .alu_func(alu_func),
        .alu_drive(alu_drive), .load_en(load_en), .cc_en(cc_en),
        .cc_load(cc_load), .addr_src(addr_src), .ar_inc(ar_inc),
        .pc_inc(pc_inc), .sp_inc(sp_inc), .sp_dec(sp_dec), .op_load(op_load),
        .upc_phase(upc_phase), .upc_opcode(upc_opcode)
    );

    // {lsel,rsel,func,drive,load_en,cc_en,cc_load,src,ar,pc,sp+,sp-,op}
    localparam logic [27:0] W_FETCH = {2'd0,2'd0,6'd0,1'b0,8'h00,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1};
    localparam logic [27:0] W_ARLO  = {2'd0,2'd0,6'd0,1'b0,8'h20,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0};
    localparam logic [27:0] W_ARHI  = {2'd0,2'd0,6'd0,1'b0,8'h40,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0};
    localparam logic [27:0] W_TLD   = {2'd0,2'd0,6'd0,1'b0,8'h04,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0};
    localparam logic [27:0] W_ADD   = {2'd0,2'd2,6'h01,1'b1,8'h01,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1};
    localparam logic [27:0] W_IDLE  = 28'h0;

    // {data_in, flag_in, expected word, expected phase, expected opcode}
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {8'h6D, 1'b0, W_FETCH, 4'd0, 8'h00},
        {8'h12, 1'b1, W_ARLO,  4'd0, 8'h6D},
        {8'h34, 1'b0, W_ARHI,  4'd1, 8'h6D},
        {8'h56, 1'b1, W_TLD,   4'd2, 8'h6D},
        {8'h6D, 1'b0, W_ADD,   4'd3, 8'h6D},
        {8'hA5, 1'b0, W_ARLO,  4'd0, 8'h6D},
        {8'h5A, 1'b1, W_ARHI,  4'd1, 8'h6D},
        {8'hC3, 1'b0, W_TLD,   4'd2, 8'h6D},
        {8'h00, 1'b1, W_ADD,   4'd3, 8'h6D},
        {8'hFF, 1'b1, W_FETCH, 4'd0, 8'h00},
        {8'h00, 1'b0, W_IDLE,  4'd0, 8'hFF},
        {8'h6D, 1'b1, W_IDLE,  4'd1, 8'hFF}
    };

    function automatic logic [27:0] act_word();
        return {alu_lsel, alu_rsel, alu_func, alu_drive, load_en, cc_en, cc_load,
                addr_src, ar_inc, pc_inc, sp_inc, sp_dec, op_load};
    endfunction

    function automatic string tag_of(logic [27:0] w);
        if (w == W_FETCH) return "R1";
        if (w == W_ARLO)  return "R4";
        if (w == W_ARHI)  return "R5";
        if (w == W_TLD)   return "R6";
        if (w == W_ADD)   return "R7";
        return "R9";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: state and word while reset is held
        repeat (3) @(negedge clk);
        #1;
        chk(upc_phase == 4'd0 && upc_opcode == 8'h00, "R1", {upc_opcode, upc_phase}, 12'h000);
        chk(act_word() == W_FETCH, "R1", act_word(), W_FETCH);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk: inputs at negedge, outputs read just after
        for (int i = 0; i < NV; i++) begin
            logic [27:0] ew;
            data_in = VEC[i][48:41];
            flag_in = VEC[i][40];
            ew = VEC[i][39:12];
            #1;
            chk(act_word() == ew, (i >= 5 && i <= 8) ? {tag_of(ew), "/R8"} : tag_of(ew), act_word(), ew);
            chk(upc_phase == VEC[i][11:8] && upc_opcode == VEC[i][7:0],
                (i == 5 || i == 9 || i == 10) ? "R2" : "R3",
                {upc_opcode, upc_phase}, {VEC[i][7:0], VEC[i][11:8]});
            chk($countones(load_en) <= 1, "R10", load_en, 8'h00);
            @(negedge clk);
        end

        // R3 wrap and R9 idle under an undefined opcode; data_in ignored
        for (int p = 2; p < 18; p++) begin
            data_in = 8'(p * 37);
            flag_in = p[0];
            #1;
            chk(upc_phase == 4'(p) && upc_opcode == 8'hFF, "R3",
                {upc_opcode, upc_phase}, {8'hFF, 4'(p)});
            chk(act_word() == W_IDLE, "R9", act_word(), W_IDLE);
            @(negedge clk);
        end

        // R1: reset in mid-run returns to fetch
        rst_n = 1'b0;
        #1;
        chk(upc_phase == 4'd0 && upc_opcode == 8'h00, "R1", {upc_opcode, upc_phase}, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        data_in = 8'h6D;
        flag_in = 1'b1;
        #1;
        chk(act_word() == W_FETCH, "R1", act_word(), W_FETCH);
        @(negedge clk);
        #1;
        chk(upc_opcode == 8'h6D && upc_phase == 4'd0, "R2", {upc_opcode, upc_phase}, 12'h6D0);
        chk(act_word() == W_ARLO, "R4/R8", act_word(), W_ARLO);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule